// File: doc/BRIEF.md
# Posit to Single-Precision Operand Decoder

This block sits in front of a shared single-precision floating-point datapath and turns a posit operand into a float32 word that the datapath can consume directly. The posit width (8 or 16 bits) and the exponent-field size (0 to 7 bits) are runtime inputs, so one piece of hardware serves configurations such as an 8-bit posit with no exponent bits and a 16-bit posit with two exponent bits. A mode input disables conversion. The same path then carries ordinary float32 operands to the datapath without changing them.

Each operand arrives with a valid strobe. The result and its valid flag come from one register stage, so the decode logic gets a full clock cycle. The decoder covers the regime run-length field, the exponent and fraction fields, the zero and not-a-real codes, and saturation or flushing when a posit scale lies outside the normal float32 range.

Top module: `posit_f32_unpack`

## Requirements
- R1: When `posit_en_i` is 0, `res_o` equals the `op_i` value presented with `vld_i` one cycle earlier, bit for bit.
- R2: `vld_o` equals `vld_i` delayed by one clock. A synchronous reset clears `vld_o` and `res_o` to 0. `res_o` keeps its value in every cycle that follows one with `vld_i` low.
- R3: `prec_i` = 2'b00 selects an 8-bit posit taken from `op_i[7:0]`, and every other code selects a 16-bit posit taken from `op_i[15:0]`. Operand bits above the selected width have no effect on the result.
- R4: `es_i` gives the exponent-field width, from 0 to 7 bits. The scale is k·2^es plus the unsigned exponent field.
- R5: An all-zero posit produces 32'h00000000.
- R6: A posit with only its sign bit set (not-a-real) produces the quiet NaN 32'h7FC00000.
- R7: For a posit whose sign bit is set, the decoder takes the two's complement of the word, decodes the magnitude, and sets bit 31 of the result.
- R8: The regime is the run of equal bits below the sign bit. A run of m ones gives k = m−1, and a run of m zeros gives k = −m. The run ends at the end of the word. Exponent bits that fall past the end of the word read as 0.
- R9: The fraction bits that remain are placed, most significant first, at bit 22 downward in the result mantissa with zero fill. The result exponent field is scale+127.
- R10: A scale above 127 produces the largest finite magnitude with the posit sign (32'h7F7FFFFF or 32'hFF7FFFFF). In posit mode the result never has exponent field 8'hFF except for the NaN of R6.
- R11: A scale below −126 produces a zero with the posit sign (32'h00000000 or 32'h80000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operand valid |
| op_i | input | 32 | Operand: a posit in its low bits, or a float32 word in bypass |
| posit_en_i | input | 1 | 1 = decode a posit, 0 = pass the operand through |
| prec_i | input | 2 | Posit width select: 2'b00 = 8-bit, other codes = 16-bit |
| es_i | input | 3 | Exponent-field width, 0 to 7 |
| vld_o | output | 1 | Result valid, one cycle after `vld_i` |
| res_o | output | 32 | Registered float32 result |

## Verification
The clocked assertions assume that reset is held for at least one edge and that `op_i`, `posit_en_i`, `prec_i` and `es_i` carry known values in any cycle where `vld_i` is high. The bypass, not-a-real and zero properties compare the registered result with the inputs of the cycle before. The bench changes inputs only on falling edges, holds reset for several cycles before the first operand, and drives every field from a defined value. This includes the spare precision codes and the full exponent-size range. Operands in bypass mode carry exponent-field patterns of all ones. The range check therefore applies only while the posit mode was enabled on the input side.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

  localparam int unsigned F32_W     = 32;
  localparam int unsigned F32_MAN_W = 23;
  localparam int          F32_BIAS  = 127;
  localparam int unsigned PREC_W    = 2;

  localparam logic [F32_W-1:0] F32_QNAN   = 32'h7FC0_0000;
  localparam logic [F32_W-2:0] F32_MAXMAG = 31'h7F7F_FFFF;

  typedef enum logic [PREC_W-1:0] {
    PREC_P8    = 2'b00,
    PREC_P16   = 2'b01,
    PREC_SPARE = 2'b10,
    PREC_WIDE  = 2'b11
  } prec_e;

endpackage

// File: rtl/posit_run_detect.sv
module posit_run_detect #(
  parameter int unsigned BODY_W = 15,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [BODY_W-1:0] body_i,
  input  logic [CNT_W-1:0]  lim_i,
  output logic              run_bit_o,
  output logic [CNT_W-1:0]  run_len_o
);

  logic [BODY_W-1:0] same;
  logic [BODY_W-1:0] in_run;

  assign run_bit_o = body_i[BODY_W-1];

  for (genvar g = 0; g < BODY_W; g++) begin : g_chain
    assign same[g] = (body_i[BODY_W-1-g] == run_bit_o);
    if (g == 0) begin : g_head
      assign in_run[g] = same[g] && (lim_i != '0);
    end else begin : g_tail
      assign in_run[g] = in_run[g-1] && same[g] && (CNT_W'(g) < lim_i);
    end
  end

  always_comb begin
    run_len_o = '0;
    for (int i = 0; i < BODY_W; i++) begin
      run_len_o = run_len_o + CNT_W'(in_run[i]);
    end
  end

  always_comb begin
    AST_RUN_BOUND: assert (run_len_o <= lim_i); // R8
  end

endmodule

// File: rtl/posit_field_split.sv
module posit_field_split #(
  parameter int unsigned BODY_W  = 15,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned ES_W    = 3,
  parameter int unsigned SCALE_W = 16
) (
  input  logic [BODY_W-1:0]         body_i,
  input  logic                      run_bit_i,
  input  logic [CNT_W-1:0]          run_len_i,
  input  logic [ES_W-1:0]           es_i,
  output logic signed [SCALE_W-1:0] scale_o,
  output logic [BODY_W-1:0]         frac_o
);

  logic [CNT_W:0]             skip;
  logic [BODY_W-1:0]          rest;
  logic [BODY_W-1:0]          ebits;
  logic signed [SCALE_W-1:0]  klen;
  logic signed [SCALE_W-1:0]  kval;

  // drop the regime run and its terminating bit; shifted-in zeros cover
  // exponent bits cut off at the end of the word
  assign skip = {1'b0, run_len_i} + 1'b1;
  assign rest = body_i << skip;

  assign ebits  = (es_i == '0) ? '0 : (rest >> (BODY_W - int'(es_i)));
  assign frac_o = rest << es_i;

  assign klen = signed'({{(SCALE_W-CNT_W){1'b0}}, run_len_i});
  assign kval = run_bit_i ? (klen - SCALE_W'(1)) : -klen;

  assign scale_o = (kval <<< es_i) + signed'({{(SCALE_W-BODY_W){1'b0}}, ebits});

endmodule

// File: rtl/posit_f32_pack.sv
module posit_f32_pack
  import posit_dec_pkg::*;
#(
  parameter int unsigned FRAC_W  = 15,
  parameter int unsigned SCALE_W = 16
) (
  input  logic                      sgn_i,
  input  logic                      zero_i,
  input  logic                      nar_i,
  input  logic signed [SCALE_W-1:0] scale_i,
  input  logic [FRAC_W-1:0]         frac_i,
  output logic [F32_W-1:0]          word_o
);

  logic [F32_MAN_W-1:0] man;
  int                   sc;

  if (FRAC_W >= F32_MAN_W) begin : g_trunc
    assign man = frac_i[FRAC_W-1 -: F32_MAN_W];
  end else begin : g_pad
    assign man = {frac_i, {(F32_MAN_W-FRAC_W){1'b0}}};
  end

  assign sc = int'(scale_i);

  always_comb begin
    if (nar_i) begin
      word_o = F32_QNAN;
    end else if (zero_i) begin
      word_o = '0;
    end else if (sc > F32_BIAS) begin
      word_o = {sgn_i, F32_MAXMAG};
    end else if (sc < (1 - F32_BIAS)) begin
      word_o = {sgn_i, {(F32_W-1){1'b0}}};
    end else begin
      word_o = {sgn_i, 8'(sc + F32_BIAS), man};
    end
  end

endmodule

// File: rtl/posit_f32_unpack.sv
module posit_f32_unpack
  import posit_dec_pkg::*;
#(
  parameter int unsigned PMAX_W = 16,
  parameter int unsigned PMIN_W = 8,
  parameter int unsigned ES_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [F32_W-1:0]  op_i,
  input  logic              posit_en_i,
  input  logic [PREC_W-1:0] prec_i,
  input  logic [ES_W-1:0]   es_i,
  output logic              vld_o,
  output logic [F32_W-1:0]  res_o
);

  localparam int unsigned BODY_W  = PMAX_W - 1;
  localparam int unsigned CNT_W   = $clog2(PMAX_W + 1);
  localparam int unsigned SCALE_W = 16;
  localparam int unsigned PAD_W   = PMAX_W - PMIN_W;

  logic                      narrow;
  logic [PMAX_W-1:0]         pw;
  logic                      sgn;
  logic                      is_zero;
  logic                      is_nar;
  logic [BODY_W-1:0]         body;
  logic [CNT_W-1:0]          lim;
  logic                      run_bit;
  logic [CNT_W-1:0]          run_len;
  logic signed [SCALE_W-1:0] scale;
  logic [BODY_W-1:0]         frac;
  logic [F32_W-1:0]          posit_word;
  logic [F32_W-1:0]          conv;

  // the narrow format is left-justified so one detector serves both widths
  assign narrow = (prec_i == PREC_P8);
  assign pw     = narrow ? {op_i[PMIN_W-1:0], {PAD_W{1'b0}}} : op_i[PMAX_W-1:0];

  assign sgn     = pw[PMAX_W-1];
  assign is_zero = (pw == '0);
  assign is_nar  = (pw == {1'b1, {(PMAX_W-1){1'b0}}});
  assign body    = sgn ? (~pw[BODY_W-1:0] + 1'b1) : pw[BODY_W-1:0];
  assign lim     = narrow ? CNT_W'(PMIN_W - 1) : CNT_W'(PMAX_W - 1);

  posit_run_detect #(
    .BODY_W (BODY_W),
    .CNT_W  (CNT_W)
  ) u_run (
    .body_i    (body),
    .lim_i     (lim),
    .run_bit_o (run_bit),
    .run_len_o (run_len)
  );

  posit_field_split #(
    .BODY_W  (BODY_W),
    .CNT_W   (CNT_W),
    .ES_W    (ES_W),
    .SCALE_W (SCALE_W)
  ) u_split (
    .body_i    (body),
    .run_bit_i (run_bit),
    .run_len_i (run_len),
    .es_i      (es_i),
    .scale_o   (scale),
    .frac_o    (frac)
  );

  posit_f32_pack #(
    .FRAC_W  (BODY_W),
    .SCALE_W (SCALE_W)
  ) u_pack (
    .sgn_i   (sgn),
    .zero_i  (is_zero),
    .nar_i   (is_nar),
    .scale_i (scale),
    .frac_i  (frac),
    .word_o  (posit_word)
  );

  assign conv = posit_en_i ? posit_word : op_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        res_o <= conv;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(res_o)); // R2
  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !posit_en_i) |=> (res_o == $past(op_i))); // R1
  AST_NAR_QNAN: assert property (@(posedge clk) disable iff (rst)
    (vld_i && posit_en_i && (prec_i == 2'b00) && (op_i[7:0] == 8'h80))
      |=> (res_o == 32'h7FC0_0000)); // R6
  AST_ZERO_P16: assert property (@(posedge clk) disable iff (rst)
    (vld_i && posit_en_i && (prec_i != 2'b00) && (op_i[15:0] == 16'h0000))
      |=> (res_o == 32'h0000_0000)); // R5
  AST_NO_INF: assert property (@(posedge clk) disable iff (rst)
    (vld_i && posit_en_i) |=> ((res_o[30:23] != 8'hFF) || (res_o == 32'h7FC0_0000))); // R10

endmodule

// File: tb/posit_f32_unpack_tb_top.sv
module posit_f32_unpack_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst;
  logic        vld_i;
  logic [31:0] op_i;
  logic        posit_en_i;
  logic [1:0]  prec_i;
  logic [2:0]  es_i;
  logic        vld_o;
  logic [31:0] res_o;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  posit_f32_unpack dut_i (
    .clk        (clk),
    .rst        (rst),
    .vld_i      (vld_i),
    .op_i       (op_i),
    .posit_en_i (posit_en_i),
    .prec_i     (prec_i),
    .es_i       (es_i),
    .vld_o      (vld_o),
    .res_o      (res_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, walking the posit bit by bit
  function automatic logic [31:0] model(logic [31:0] op, bit en, logic [1:0] prec, int es);
    int n, i, m, k, e, sc, pos;
    logic [15:0] p;
    logic [22:0] man;
    bit s, r0;
    if (!en) return op;
    n = (prec == 2'b00) ? 8 : 16;
    p = (n == 8) ? {8'h00, op[7:0]} : op[15:0];
    if (p == 16'h0000) return 32'h0;
    if (p == 16'(1 << (n-1))) return 32'h7FC0_0000;
    s = p[n-1];
    if (s) p = (~p + 16'h1) & 16'((1 << n) - 1);
    i = n - 2; r0 = p[i]; m = 0;
    while (i >= 0 && p[i] == r0) begin m++; i--; end
    k = r0 ? m - 1 : -m;
    i--;
    e = 0;
    for (int j = 0; j < es; j++) begin
      e = e * 2 + ((i >= 0) ? int'(p[i]) : 0);
      i--;
    end
    man = '0; pos = 22;
    while (i >= 0) begin man[pos] = p[i]; pos--; i--; end
    sc = k * (1 << es) + e;
    if (sc > 127)  return {s, 31'h7F7F_FFFF};
    if (sc < -126) return {s, 31'h0};
    return {s, 8'(sc + 127), man};
  endfunction

  task automatic drive(logic [31:0] op, bit en, logic [1:0] prec, int es,
                       string tag, logic [31:0] expv);
    @(negedge clk);
    vld_i      = 1'b1;
    op_i       = op;
    posit_en_i = en;
    prec_i     = prec;
    es_i       = 3'(es);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic idle(logic [31:0] op);
    @(negedge clk);
    vld_i = 1'b0;
    op_i  = op;
  endtask

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, expv);
    end
  endtask

  // monitor: pops the scoreboard whenever a result is flagged valid
  always @(negedge clk) begin
    if (!rst && vld_o && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected vld_o", res_o, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_o === e, t, res_o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; vld_i = 1'b0; op_i = 32'h0; posit_en_i = 1'b0; prec_i = 2'b00; es_i = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(res_o === 32'h0 && vld_o === 1'b0, "R2 reset state", res_o, 32'h0);
    rst = 1'b0;

    drive(32'hDEAD_BEEF, 0, 2'b00, 0, "R1 bypass",      32'hDEAD_BEEF);
    drive(32'h7F80_0001, 0, 2'b01, 5, "R1 bypass nan",  32'h7F80_0001);
    drive(32'h0000_0000, 1, 2'b01, 2, "R5 zero p16",    32'h0000_0000);
    drive(32'hFFFF_0000, 1, 2'b00, 0, "R5 R3 zero p8",  32'h0000_0000);
    drive(32'h0000_0080, 1, 2'b00, 0, "R6 nar p8",      32'h7FC0_0000);
    drive(32'h0000_8000, 1, 2'b01, 7, "R6 nar p16",     32'h7FC0_0000);
    drive(32'hABCD_0040, 1, 2'b00, 0, "R3 upper bits",  32'h3F80_0000);
    drive(32'h0000_4000, 1, 2'b11, 2, "R3 code 11",     32'h3F80_0000);
    drive(32'h0000_0050, 1, 2'b00, 0, "R9 fraction",    32'h3FC0_0000);
    drive(32'h0000_5000, 1, 2'b01, 2, "R4 es2",         32'h4080_0000);
    drive(32'h0000_007F, 1, 2'b00, 0, "R8 max p8",      32'h4280_0000);
    drive(32'h0000_7FFF, 1, 2'b01, 2, "R8 max p16",     32'h5B80_0000);
    drive(32'h0000_007E, 1, 2'b00, 3, "R8 cut exp",     32'h5380_0000);
    drive(32'h0000_00C0, 1, 2'b00, 0, "R7 neg p8",      32'hBF80_0000);
    drive(32'h0000_B000, 1, 2'b01, 2, "R7 neg p16",     32'hC080_0000);
    drive(32'h0000_7FFF, 1, 2'b01, 7, "R10 clamp pos",  32'h7F7F_FFFF);
    drive(32'h0000_8001, 1, 2'b01, 7, "R10 clamp neg",  32'hFF7F_FFFF);
    drive(32'h0000_0001, 1, 2'b01, 7, "R11 flush pos",  32'h0000_0000);
    drive(32'h0000_FFFF, 1, 2'b01, 7, "R11 flush neg",  32'h8000_0000);
    idle(32'h1234_5678);
    repeat (2) @(negedge clk);
    check(res_o === 32'h8000_0000 && vld_o === 1'b0, "R2 hold when idle", res_o, 32'h8000_0000);

    for (int es = 0; es < 8; es++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] op;
        op = {24'h5A5A5A, 8'(v)};
        drive(op, 1, 2'b00, es, "R8 sweep p8", model(op, 1, 2'b00, es));
      end
    end
    foreach (es_list[idx]) begin end
    for (int sel = 0; sel < 5; sel++) begin
      int es;
      es = (sel == 4) ? 7 : sel;
      for (int v = 0; v < 65536; v += 97) begin
        logic [31:0] op;
        op = {16'hC3C3, 16'(v)};
        drive(op, 1, 2'(1 + (sel % 3)), es, "R9 sweep p16", model(op, 1, 2'(1 + (sel % 3)), es));
      end
    end
    drive(32'h3F80_0000, 0, 2'b01, 3, "R1 bypass after sweep", 32'h3F80_0000);
    idle(32'h0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results seen", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int es_list[1] = '{0};

endmodule